// File: doc/BRIEF.md
# Hypervisor Virtual CPU Interface Register File

This block is the register file that a hypervisor uses to manage one virtual CPU interface of an interrupt controller. It decodes single-cycle 32-bit word reads and writes on a simple request bus. It holds a hypervisor control word, the virtual CPU interface state (control bits, two binary points and a priority mask), an active-priorities word and a parameterised set of list registers. A write to the active-priorities word also derives a running priority.

Several read-only words are computed live from the list-register contents. These are an end-of-interrupt status pair, an empty-entry status pair, a type word that describes the configuration, and a maintenance status word that external logic supplies. Interrupt prioritisation, signalling to the virtual CPU and generation of the maintenance interrupt live outside this block.

Read data is registered and returns one cycle after the request.

Top module: `hv_vif_regs`

## Requirements
- R1: After reset, the hypervisor control, active-priorities and all list-register words read 0. The virtual control word reads binary point MIN_BPR and aliased binary point MIN_BPR+1, with a zero control field and a zero priority mask. `vif_rprio` is 0xFF.
- R2: A read request (`req_valid`=1, `req_write`=0) raises `rd_valid` for exactly the next cycle, with `rd_data` holding the addressed word. In all other cycles `rd_valid` is 0.
- R3: The hypervisor control word at offset 0x000 stores the written data ANDed with HCR_MASK (default 0xF80000FF).
- R4: List register n sits at offset 0x100+4n, for n from 0 to 63. A write stores the data ANDed with LR_MASK (default 0xFF8FFFFF). For n ≥ NUM_LR, reads return 0 and writes change nothing. List-register layout: [29:28] state (0 = invalid), bit 31 hardware-linked, bit 19 EOI-notify when not hardware-linked.
- R5: The virtual control word at offset 0x008 packs these fields: [9:0] control, [20:18] aliased binary point, [23:21] binary point, [31:27] priority mask. The priority mask is stored as an 8-bit value equal to the written field shifted left by 3, and a read returns its bits [7:3]. All other bits read 0. The stored values appear on `vif_ctl`, `vif_abpr`, `vif_bpr` and `vif_pmask`.
- R6: On a write to the virtual control word, the binary point is stored as max(written, MIN_BPR) and the aliased binary point as max(written, MIN_BPR+1).
- R7: The active-priorities word at offset 0x0F0 stores all 32 bits. The same write sets `vif_rprio` to (index of the lowest set bit) × 2^(8−PRE_BITS), or to 0xFF when no bit is set. No other access changes `vif_rprio`.
- R8: The end-of-interrupt status words sit at 0x020 and 0x024. Bit i of the first word reflects list register i, and bit i of the second reflects list register 32+i. A bit is 1 when that entry has state 0, bit 31 clear and bit 19 set. Bits for unimplemented entries read 0.
- R9: The empty status words sit at 0x030 and 0x034, with the same bit mapping as R8. A bit is 1 when that entry has state 0 and does not hold a pending end-of-interrupt as defined in R8. Bits for unimplemented entries read 0.
- R10: The type word at 0x004 reads NUM_LR−1 in [5:0], PRE_BITS−1 in [28:26] and (7−MIN_BPR)−1 in [31:29]. All other bits read 0, and writes to it are ignored.
- R11: The word at 0x010 reads the current `maint_status` input.
- R12: Reads of any other offset, or of any offset whose bits [1:0] are nonzero, return 0. Writes to such offsets, and to the read-only words, change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| maint_status | input | 32 | Maintenance status from external logic |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| vif_ctl | output | 10 | Virtual CPU control field |
| vif_abpr | output | 3 | Aliased binary point |
| vif_bpr | output | 3 | Binary point |
| vif_pmask | output | 8 | Priority mask |
| vif_rprio | output | 8 | Running priority |

## Verification
Random word streams are written to every defined offset, to list-register slots above and below the implemented count, and to undefined or misaligned offsets. A shadow model then reads each one back. This separates correct masking and ignored writes from stray updates. Directed list-register contents cover the four combinations of state, hardware link and EOI-notify, so that the EOI and empty vectors are told apart. The instance uses more than 32 entries so that the second status word carries live bits. Binary-point writes below, at and above the floors test the clamps, and active-priority patterns with single, multiple and no set bits test the lowest-bit rule and the 0xFF value.

// File: rtl/hv_vif_pkg.sv
package hv_vif_pkg;

    localparam int ADDR_W = 9;

    localparam logic [ADDR_W-1:0] OFF_HCR    = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_TYPE   = 9'h004;
    localparam logic [ADDR_W-1:0] OFF_VMCTL  = 9'h008;
    localparam logic [ADDR_W-1:0] OFF_MAINT  = 9'h010;
    localparam logic [ADDR_W-1:0] OFF_EOI0   = 9'h020;
    localparam logic [ADDR_W-1:0] OFF_EOI1   = 9'h024;
    localparam logic [ADDR_W-1:0] OFF_EMPTY0 = 9'h030;
    localparam logic [ADDR_W-1:0] OFF_EMPTY1 = 9'h034;
    localparam logic [ADDR_W-1:0] OFF_APR    = 9'h0F0;

    // virtual control word field positions
    localparam int VM_ABP_LSB = 18;
    localparam int VM_BP_LSB  = 21;
    localparam int VM_PM_LSB  = 27;

    // list register fields used by the status vectors
    localparam int LR_EOI_BIT = 19;
    localparam int LR_ST_LSB  = 28;
    localparam int LR_HW_BIT  = 31;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_HCR,
        SEL_TYPE,
        SEL_VMCTL,
        SEL_MAINT,
        SEL_EOI0,
        SEL_EOI1,
        SEL_EMP0,
        SEL_EMP1,
        SEL_APR,
        SEL_LR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[8]) begin
                s = SEL_LR;
            end else begin
                case (a)
                    OFF_HCR:    s = SEL_HCR;
                    OFF_TYPE:   s = SEL_TYPE;
                    OFF_VMCTL:  s = SEL_VMCTL;
                    OFF_MAINT:  s = SEL_MAINT;
                    OFF_EOI0:   s = SEL_EOI0;
                    OFF_EOI1:   s = SEL_EOI1;
                    OFF_EMPTY0: s = SEL_EMP0;
                    OFF_EMPTY1: s = SEL_EMP1;
                    OFF_APR:    s = SEL_APR;
                    default:    s = SEL_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/hv_lr_status.sv
module hv_lr_status #(
    parameter int NUM_LR = 4
) (
    input  logic [NUM_LR*32-1:0] lr_flat,
    output logic [63:0]          eoi_vec,
    output logic [63:0]          empty_vec
);
    import hv_vif_pkg::*;

    for (genvar i = 0; i < 64; i++) begin : g_ent
        if (i < NUM_LR) begin : g_live
            logic [31:0] ent;
            logic        st_zero;
            logic        eoi_pend;
            assign ent      = lr_flat[i*32 +: 32];
            assign st_zero  = (ent[LR_ST_LSB +: 2] == 2'b00);
            assign eoi_pend = !ent[LR_HW_BIT] && ent[LR_EOI_BIT];
            assign eoi_vec[i]   = st_zero && eoi_pend;
            assign empty_vec[i] = st_zero && !eoi_pend;
        end else begin : g_absent
            assign eoi_vec[i]   = 1'b0;
            assign empty_vec[i] = 1'b0;
        end
    end

endmodule

// File: rtl/hv_rprio.sv
module hv_rprio #(
    parameter int PRE_BITS = 5
) (
    input  logic [31:0] apr,
    output logic [7:0]  prio
);
    localparam int NGRP = ((1 << PRE_BITS) > 32) ? 32 : (1 << PRE_BITS);
    localparam int STEP = 1 << (8 - PRE_BITS);

    logic [NGRP-1:0] used;
    assign used = apr[NGRP-1:0];

    always_comb begin
        prio = 8'hFF;
        for (int i = NGRP - 1; i >= 0; i--) begin
            if (used[i]) begin
                prio = 8'(i * STEP);
            end
        end
    end

endmodule

// File: rtl/hv_rd_mux.sv
module hv_rd_mux #(
    parameter int NUM_LR = 4
) (
    input  hv_vif_pkg::reg_sel_e sel,
    input  logic [5:0]           lr_idx,
    input  logic [31:0]          hcr_word,
    input  logic [31:0]          type_word,
    input  logic [31:0]          vmctl_word,
    input  logic [31:0]          maint_word,
    input  logic [31:0]          apr_word,
    input  logic [63:0]          eoi_vec,
    input  logic [63:0]          empty_vec,
    input  logic [NUM_LR*32-1:0] lr_flat,
    output logic [31:0]          data
);
    import hv_vif_pkg::*;

    logic [31:0] lr_word;

    always_comb begin
        lr_word = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lr_idx == 6'(i)) begin
                lr_word = lr_flat[i*32 +: 32];
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_HCR:   data = hcr_word;
            SEL_TYPE:  data = type_word;
            SEL_VMCTL: data = vmctl_word;
            SEL_MAINT: data = maint_word;
            SEL_EOI0:  data = eoi_vec[31:0];
            SEL_EOI1:  data = eoi_vec[63:32];
            SEL_EMP0:  data = empty_vec[31:0];
            SEL_EMP1:  data = empty_vec[63:32];
            SEL_APR:   data = apr_word;
            SEL_LR:    data = lr_word;
            default:   data = '0;
        endcase
    end

endmodule

// File: rtl/hv_vif_regs.sv
module hv_vif_regs #(
    parameter int          NUM_LR   = 4,
    parameter int          PRE_BITS = 5,
    parameter int          MIN_BPR  = 2,
    parameter logic [31:0] HCR_MASK = 32'hF800_00FF,
    parameter logic [31:0] LR_MASK  = 32'hFF8F_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [8:0]  req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] maint_status,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic [9:0]  vif_ctl,
    output logic [2:0]  vif_abpr,
    output logic [2:0]  vif_bpr,
    output logic [7:0]  vif_pmask,
    output logic [7:0]  vif_rprio
);
    import hv_vif_pkg::*;

    localparam int          MIN_ABPR    = MIN_BPR + 1;
    localparam int          PRI_BITS_M1 = (7 - MIN_BPR) - 1;
    localparam logic [2:0]  BPR_FLOOR   = 3'(MIN_BPR);
    localparam logic [2:0]  ABPR_FLOOR  = 3'(MIN_ABPR);
    localparam logic [31:0] TYPE_WORD   = {3'(PRI_BITS_M1), 3'(PRE_BITS - 1),
                                           20'b0, 6'(NUM_LR - 1)};

    typedef struct packed {
        logic [31:0]             hcr;
        logic [9:0]              ctl;
        logic [2:0]              bpr;
        logic [2:0]              abpr;
        logic [7:0]              pmask;
        logic [31:0]             apr;
        logic [7:0]              rprio;
        logic [NUM_LR-1:0][31:0] lr;
        logic                    rvalid;
        logic [31:0]             rdata;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e            sel;
    logic [5:0]          lr_idx;
    logic [NUM_LR*32-1:0] lr_flat;
    logic [63:0]         eoi_vec;
    logic [63:0]         empty_vec;
    logic [7:0]          new_prio;
    logic [31:0]         vmctl_word;
    logic [31:0]         mux_data;
    logic [2:0]          wr_bp;
    logic [2:0]          wr_abp;

    assign sel     = decode_addr(req_addr);
    assign lr_idx  = req_addr[7:2];
    assign lr_flat = st_q.lr;
    assign wr_bp   = req_wdata[VM_BP_LSB +: 3];
    assign wr_abp  = req_wdata[VM_ABP_LSB +: 3];

    assign vmctl_word = {st_q.pmask[7:3], 3'b0, st_q.bpr, st_q.abpr, 8'b0, st_q.ctl};

    hv_lr_status #(.NUM_LR(NUM_LR)) status_i (
        .lr_flat   (lr_flat),
        .eoi_vec   (eoi_vec),
        .empty_vec (empty_vec)
    );

    hv_rprio #(.PRE_BITS(PRE_BITS)) rprio_i (
        .apr  (req_wdata),
        .prio (new_prio)
    );

    hv_rd_mux #(.NUM_LR(NUM_LR)) mux_i (
        .sel        (sel),
        .lr_idx     (lr_idx),
        .hcr_word   (st_q.hcr),
        .type_word  (TYPE_WORD),
        .vmctl_word (vmctl_word),
        .maint_word (maint_status),
        .apr_word   (st_q.apr),
        .eoi_vec    (eoi_vec),
        .empty_vec  (empty_vec),
        .lr_flat    (lr_flat),
        .data       (mux_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (req_valid && req_write) begin
            case (sel)
                SEL_HCR: st_d.hcr = req_wdata & HCR_MASK;
                SEL_VMCTL: begin
                    st_d.ctl   = req_wdata[9:0];
                    st_d.bpr   = (wr_bp  < BPR_FLOOR)  ? BPR_FLOOR  : wr_bp;
                    st_d.abpr  = (wr_abp < ABPR_FLOOR) ? ABPR_FLOOR : wr_abp;
                    st_d.pmask = {req_wdata[VM_PM_LSB +: 5], 3'b000};
                end
                SEL_APR: begin
                    st_d.apr   = req_wdata;
                    st_d.rprio = new_prio;
                end
                SEL_LR: begin
                    for (int i = 0; i < NUM_LR; i++) begin
                        if (lr_idx == 6'(i)) begin
                            st_d.lr[i] = req_wdata & LR_MASK;
                        end
                    end
                end
                default: ;
            endcase
        end else if (req_valid) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = mux_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bpr   <= BPR_FLOOR;
            st_q.abpr  <= ABPR_FLOOR;
            st_q.rprio <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid  = st_q.rvalid;
    assign rd_data   = st_q.rdata;
    assign vif_ctl   = st_q.ctl;
    assign vif_abpr  = st_q.abpr;
    assign vif_bpr   = st_q.bpr;
    assign vif_pmask = st_q.pmask;
    assign vif_rprio = st_q.rprio;

endmodule

// File: rtl/hv_vif_regs_chk.sv
module hv_vif_regs_chk #(
    parameter int MIN_BPR = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic       rd_valid,
    input logic [2:0] vif_bpr,
    input logic [2:0] vif_abpr,
    input logic [7:0] vif_pmask,
    input logic [7:0] vif_rprio
);
    localparam logic [2:0] BPR_FLOOR  = 3'(MIN_BPR);
    localparam logic [2:0] ABPR_FLOOR = 3'(MIN_BPR + 1);

    // R2
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R6
    bpr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vif_bpr >= BPR_FLOOR);

    // R6
    abpr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vif_abpr >= ABPR_FLOOR);

    // R5
    pmask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vif_pmask[2:0] == 3'b000);

    // R7
    rprio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(vif_rprio));

endmodule

bind hv_vif_regs hv_vif_regs_chk #(.MIN_BPR(MIN_BPR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_valid  (rd_valid),
    .vif_bpr   (vif_bpr),
    .vif_abpr  (vif_abpr),
    .vif_pmask (vif_pmask),
    .vif_rprio (vif_rprio)
);

// File: tb/hv_vif_regs_tb_top.sv
module hv_vif_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] maint_status = 32'h1234_5678;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [9:0]  vif_ctl;
    logic [2:0]  vif_abpr;
    logic [2:0]  vif_bpr;
    logic [7:0]  vif_pmask;
    logic [7:0]  vif_rprio;

    int n_chk = 0;
    int n_err = 0;

    // shadow model
    logic [31:0] m_hcr = '0;
    logic [31:0] m_apr = '0;
    logic [31:0] m_lr [64];
    logic [9:0]  m_ctl = '0;
    logic [2:0]  m_bpr = 3'd2;
    logic [2:0]  m_abpr = 3'd3;
    logic [7:0]  m_pm = '0;
    logic [7:0]  m_rp = 8'hFF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hv_vif_regs #(.NUM_LR(NL)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .maint_status (maint_status),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .vif_ctl      (vif_ctl),
        .vif_abpr     (vif_abpr),
        .vif_bpr      (vif_bpr),
        .vif_pmask    (vif_pmask),
        .vif_rprio    (vif_rprio)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic lr_eoi(input logic [31:0] e);
        return (e[29:28] == 2'b00) && !e[31] && e[19];
    endfunction

    function automatic logic lr_empty(input logic [31:0] e);
        return (e[29:28] == 2'b00) && !(!e[31] && e[19]);
    endfunction

    function automatic logic [7:0] prio_of(input logic [31:0] a);
        for (int i = 0; i < 32; i++) begin
            if (a[i]) return 8'(i * 8);
        end
        return 8'hFF;
    endfunction

    function automatic logic [2:0] clampv(input logic [2:0] v, input logic [2:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [8:0] a);
        logic [31:0] r;
        r = '0;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a[8]) begin
            if (int'(a[7:2]) < NL) r = m_lr[a[7:2]];
            return r;
        end
        case (a)
            9'h000: r = m_hcr;
            9'h004: r = {3'd4, 3'd4, 20'b0, 6'(NL - 1)};
            9'h008: r = {m_pm[7:3], 3'b0, m_bpr, m_abpr, 8'b0, m_ctl};
            9'h010: r = maint_status;
            9'h020: for (int i = 0; i < 32; i++) r[i] = (i < NL) && lr_eoi(m_lr[i]);
            9'h024: for (int i = 0; i < 32; i++) r[i] = (i + 32 < NL) && lr_eoi(m_lr[i + 32]);
            9'h030: for (int i = 0; i < 32; i++) r[i] = (i < NL) && lr_empty(m_lr[i]);
            9'h034: for (int i = 0; i < 32; i++) r[i] = (i + 32 < NL) && lr_empty(m_lr[i + 32]);
            9'h0F0: r = m_apr;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_wr(input logic [8:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a[8]) begin
            if (int'(a[7:2]) < NL) m_lr[a[7:2]] = d & 32'hFF8F_FFFF;
            return;
        end
        case (a)
            9'h000: m_hcr = d & 32'hF800_00FF;
            9'h008: begin
                m_ctl  = d[9:0];
                m_abpr = clampv(d[20:18], 3'd3);
                m_bpr  = clampv(d[23:21], 3'd2);
                m_pm   = {d[31:27], 3'b0};
            end
            9'h0F0: begin
                m_apr = d;
                m_rp  = prio_of(d);
            end
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        model_wr(a, d);
    endtask

    task automatic bus_rd_chk(input string req, input logic [8:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rd_valid"}, 32'(rd_valid), 32'h1);
        check(req, rd_data, exp_rd(a));
    endtask

    function automatic logic [8:0] rand_addr();
        int k;
        k = int'($urandom % 14);
        case (k)
            0:  return 9'h000;
            1:  return 9'h004;
            2:  return 9'h008;
            3:  return 9'h010;
            4:  return 9'h020;
            5:  return 9'h024;
            6:  return 9'h030;
            7:  return 9'h034;
            8:  return 9'h0F0;
            9:  return 9'(32'h100 + 4 * ($urandom % 64));
            10: return 9'(32'h100 + 4 * ($urandom % NL));
            11: return 9'(32'h100 + 4 * (NL - 1 + ($urandom % 3)));
            12: return 9'($urandom);
            default: return {7'($urandom), 2'b01};
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog timeout");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) m_lr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 rprio", 32'(vif_rprio), 32'hFF);
        check("R1 bpr", 32'(vif_bpr), 32'd2);
        check("R1 abpr", 32'(vif_abpr), 32'd3);
        check("R2 idle rd_valid", 32'(rd_valid), 32'h0);
        bus_rd_chk("R1 hcr", 9'h000);
        bus_rd_chk("R1 vmctl", 9'h008);
        bus_rd_chk("R1 apr", 9'h0F0);
        bus_rd_chk("R1 lr0", 9'h100);
        bus_rd_chk("R9 empty after reset", 9'h030);
        bus_rd_chk("R9 empty word1 after reset", 9'h034);
        @(negedge clk);
        check("R2 rd_valid single cycle", 32'(rd_valid), 32'h0);

        // R10 type word, read only
        bus_rd_chk("R10 type", 9'h004);
        bus_wr(9'h004, 32'hFFFF_FFFF);
        bus_rd_chk("R10 type after write", 9'h004);

        // R11 maint passthrough
        maint_status = 32'hCAFE_0001;
        bus_rd_chk("R11 maint", 9'h010);

        // R3 masked write
        bus_wr(9'h000, 32'hFFFF_FFFF);
        bus_rd_chk("R3 hcr mask", 9'h000);

        // R4 list registers: mask, top valid slot, beyond count
        bus_wr(9'h100, 32'hFFFF_FFFF);
        bus_rd_chk("R4 lr0 mask", 9'h100);
        bus_wr(9'(32'h100 + 4 * (NL - 1)), 32'h0008_0123);
        bus_rd_chk("R4 last lr", 9'(32'h100 + 4 * (NL - 1)));
        bus_wr(9'(32'h100 + 4 * NL), 32'hA5A5_A5A5);
        bus_rd_chk("R4 lr beyond count", 9'(32'h100 + 4 * NL));
        bus_rd_chk("R4 lr 63", 9'h1FC);

        // R8 R9 four state combos
        bus_wr(9'h104, 32'h0008_0000);   // inv, sw, eoi -> eoi
        bus_wr(9'h108, 32'h8008_0000);   // inv, hw -> empty
        bus_wr(9'h10C, 32'h0000_0000);   // inv, no eoi -> empty
        bus_wr(9'h110, 32'h1008_0000);   // pending -> neither
        bus_wr(9'h180, 32'h0008_0000);   // lr 32 eoi
        bus_rd_chk("R8 eoi word0", 9'h020);
        bus_rd_chk("R8 eoi word1", 9'h024);
        bus_rd_chk("R9 empty word0", 9'h030);
        bus_rd_chk("R9 empty word1", 9'h034);

        // R5 R6 packing and clamp
        bus_wr(9'h008, {5'b10101, 3'b111, 3'd0, 3'd1, 8'hFF, 10'h2AB});
        check("R6 bpr clamp low", 32'(vif_bpr), 32'd2);
        check("R6 abpr clamp low", 32'(vif_abpr), 32'd3);
        check("R5 pmask shift", 32'(vif_pmask), 32'hA8);
        check("R5 ctl", 32'(vif_ctl), 32'h2AB);
        bus_rd_chk("R5 vmctl read", 9'h008);
        bus_wr(9'h008, {5'b00011, 3'b0, 3'd6, 3'd3, 8'h0, 10'h001});
        check("R6 bpr pass", 32'(vif_bpr), 32'd6);
        check("R6 abpr at floor", 32'(vif_abpr), 32'd3);
        bus_rd_chk("R5 vmctl read 2", 9'h008);

        // R7 running priority
        bus_wr(9'h0F0, 32'h0000_0000);
        check("R7 rprio none", 32'(vif_rprio), 32'hFF);
        bus_wr(9'h0F0, 32'h8000_0010);
        check("R7 rprio lowest", 32'(vif_rprio), 32'h20);
        bus_wr(9'h0F0, 32'h0000_0001);
        check("R7 rprio bit0", 32'(vif_rprio), 32'h00);
        bus_wr(9'h000, 32'h0);
        check("R7 rprio kept", 32'(vif_rprio), 32'h00);

        // R12 undefined and misaligned
        bus_wr(9'h0C0, 32'hFFFF_FFFF);
        bus_wr(9'h101, 32'hFFFF_FFFF);
        bus_rd_chk("R12 undef read", 9'h0C0);
        bus_rd_chk("R12 misaligned read", 9'h101);
        bus_rd_chk("R12 lr0 untouched", 9'h100);
        bus_rd_chk("R12 hcr untouched", 9'h000);

        // random mix
        for (int n = 0; n < 1500; n++) begin
            logic [8:0] a;
            a = rand_addr();
            if ($urandom % 2 == 0) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom % 4 == 0) d[29:28] = 2'b00;
                bus_wr(a, d);
                check("R7 rprio random", 32'(vif_rprio), 32'(m_rp));
                check("R6 bpr random", 32'(vif_bpr), 32'(m_bpr));
                check("R5 pmask random", 32'(vif_pmask), 32'(m_pm));
            end else begin
                maint_status = $urandom;
                bus_rd_chk("R12 R4 R8 R9 random read", a);
            end
        end

        // full readback of state
        for (int i = 0; i < 64; i++) bus_rd_chk("R4 final lr", 9'(32'h100 + 4 * i));
        bus_rd_chk("R8 final eoi0", 9'h020);
        bus_rd_chk("R9 final empty1", 9'h034);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule